// File: doc/BRIEF.md
# Predicated Vector Element Loop Sequencer

This block walks a vector operation one element per clock. A `start` pulse captures the operation's setup: vector length, sub-vector grouping, first group index, scalar/vector flags and base register numbers for one source and one destination, a 3-bit twin-predicate selector, and the two predicate masks, already read from their registers. From the next cycle on, the block hands one source/destination register pair per cycle to a single ALU slot. It raises `issue` for each pair and pulses `done` when the loop is exhausted.

Each operand keeps its own group index. Each index jumps in one cycle past groups that its predicate disables, so every issued cycle carries useful work. One predicate bit covers a whole group of sub-vector elements. A scalar operand keeps its register number from group to group. If a scalar operand is predicated, the loop ends after the first enabled group. A trap freezes the loop and leaves the group index to resume from on `resume_idx`. A clean finish returns that index to zero.

Top module: `vec_elem_seq`

## Requirements
- R1: When idle, a `start` pulse captures all setup inputs and `busy` is high in the following cycle. `start` and all setup inputs are ignored while `busy` is high.
- R2: A vector operand's register number is base + group*L + e, modulo 128, where L is the group length and e is the element within the group. A scalar operand's register number is base + e, whatever the group.
- R3: The group length code maps 00, 01, 10 and 11 to 1, 2, 3 and 4 elements. All elements of a group issue on consecutive cycles in increasing e, and one predicate bit covers the whole group.
- R4: Selector bit 0 predicates the source with `src_mask`. Bit 1 predicates the destination with `dst_mask`. Bit 2 inverts whichever masks are in use. Selector 100 is therefore unpredicated, and a group g is enabled when mask bit g XOR bit 2 is 1.
- R5: Source and destination indices each advance independently to their next enabled group below VL. The n-th enabled source group is paired with the n-th enabled destination group. One element is issued per cycle with no idle cycles between issues.
- R6: When a predicated operand is scalar, the loop ends after the first issued group.
- R7: Iteration starts at `start_idx`. When either index finds no enabled group below VL, `done` pulses for one cycle, one cycle after the last issue. `busy` falls and `resume_idx` becomes 0. With VL=0 or `start_idx` >= VL, nothing issues and `done` pulses in the first cycle after `busy` rises.
- R8: A `trap` seen while busy suppresses issue in that cycle, drops `busy` without `done`, and sets `resume_idx` to the destination group index the sequencer was working on. A `trap` while idle changes nothing.
- R9: `issue` and `done` are never high together, and `busy` is low whenever `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a loop (sampled when idle) |
| vl | input | 7 | Vector length in groups, 0..64 |
| svlen_code | input | 2 | Group length code (length = code+1) |
| start_idx | input | 7 | First group index |
| src_vec | input | 1 | Source operand is a vector (0 = scalar) |
| dst_vec | input | 1 | Destination operand is a vector (0 = scalar) |
| src_base | input | 7 | Source base register number |
| dst_base | input | 7 | Destination base register number |
| pred_sel | input | 3 | Twin-predicate selector |
| src_mask | input | 64 | Source predicate mask, one bit per group |
| dst_mask | input | 64 | Destination predicate mask, one bit per group |
| trap | input | 1 | Freeze the running loop |
| busy | output | 1 | Loop in progress |
| issue | output | 1 | A register pair is valid this cycle |
| src_reg | output | 7 | Source register number |
| dst_reg | output | 7 | Destination register number |
| done | output | 1 | Loop finished (one-cycle pulse) |
| resume_idx | output | 7 | Group index to resume from |

## Verification
The hardest case to reach is a trap that lands partway through a loop, followed by a restart from the recorded index. It has to reproduce the rest of the trace exactly. The stimulus counts issued pairs at the ports and raises `trap` after a chosen count. It then checks that `resume_idx` is unchanged by a further trap while idle, and restarts with `start_idx` set to that value. Twin predication with differently populated, inverted masks and a predicated scalar are the other hard shapes. These runs confirm that the two indices skip independently and that the loop cuts off after the first group.

// File: rtl/vec_elem_seq_pkg.sv
package vec_elem_seq_pkg;

    localparam int VES_MAXVL = 64;
    localparam int VES_REG_W = 7;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic inv;
        logic dst_on;
        logic src_on;
    } pred_ctl_t;

    // Bit 0 gates the source, bit 1 the destination, bit 2 inverts.
    // The reserved value 100 enables neither mask, so it is unpredicated.
    function automatic pred_ctl_t decode_pred(input logic [2:0] sel);
        pred_ctl_t p;
        p.src_on = sel[0];
        p.dst_on = sel[1];
        p.inv    = sel[2];
        return p;
    endfunction

    function automatic logic [2:0] group_len(input logic [1:0] code);
        return {1'b0, code} + 3'd1;
    endfunction

endpackage

// File: rtl/ves_next_pick.sv
module ves_next_pick #(
    parameter int MAXVL = 64,
    parameter int IDX_W = 7
) (
    input  logic [MAXVL-1:0] mask_i,
    input  logic             on_i,
    input  logic             inv_i,
    input  logic [IDX_W-1:0] from_i,
    input  logic [IDX_W-1:0] limit_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o
);
    // Scan downward so the lowest qualifying index is the one that remains.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = MAXVL - 1; i >= 0; i--) begin
            if (IDX_W'(i) >= from_i && IDX_W'(i) < limit_i &&
                (!on_i || (mask_i[i] ^ inv_i))) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/ves_reg_map.sv
module ves_reg_map #(
    parameter int IDX_W = 7,
    parameter int REG_W = 7
) (
    input  logic [REG_W-1:0] base_i,
    input  logic             is_vec_i,
    input  logic [IDX_W-1:0] grp_i,
    input  logic [2:0]       glen_i,
    input  logic [1:0]       elem_i,
    output logic [REG_W-1:0] reg_o
);
    localparam int OFF_W = IDX_W + 3;

    logic [OFF_W-1:0]       off;
    logic [OFF_W+REG_W-1:0] sum;

    always_comb begin
        off = is_vec_i ? ({3'b000, grp_i} * {{IDX_W{1'b0}}, glen_i}) : '0;
        off = off + {{(IDX_W + 1){1'b0}}, elem_i};
        sum = {{OFF_W{1'b0}}, base_i} + {{REG_W{1'b0}}, off};
        reg_o = sum[REG_W-1:0];
    end
endmodule

// File: rtl/vec_elem_seq.sv
module vec_elem_seq
    import vec_elem_seq_pkg::*;
#(
    parameter int MAXVL = VES_MAXVL,
    parameter int REG_W = VES_REG_W,
    localparam int IDX_W = $clog2(MAXVL + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [IDX_W-1:0] vl,
    input  logic [1:0]       svlen_code,
    input  logic [IDX_W-1:0] start_idx,
    input  logic             src_vec,
    input  logic             dst_vec,
    input  logic [REG_W-1:0] src_base,
    input  logic [REG_W-1:0] dst_base,
    input  logic [2:0]       pred_sel,
    input  logic [MAXVL-1:0] src_mask,
    input  logic [MAXVL-1:0] dst_mask,
    input  logic             trap,
    output logic             busy,
    output logic             issue,
    output logic [REG_W-1:0] src_reg,
    output logic [REG_W-1:0] dst_reg,
    output logic             done,
    output logic [IDX_W-1:0] resume_idx
);
    seq_state_e       state_q;
    logic [IDX_W-1:0] vl_q, s_idx_q, d_idx_q;
    logic [2:0]       glen_q;
    logic [1:0]       elem_q;
    logic             svec_q, dvec_q;
    logic [REG_W-1:0] sbase_q, dbase_q;
    pred_ctl_t        pc_q;
    logic [MAXVL-1:0] smask_q, dmask_q;

    logic             s_found, d_found, pair_ok, last_elem, cut_short;
    logic [IDX_W-1:0] s_pick, d_pick;
    logic [REG_W-1:0] s_reg_nx, d_reg_nx;

    ves_next_pick #(.MAXVL(MAXVL), .IDX_W(IDX_W)) i_pick_src (
        .mask_i(smask_q), .on_i(pc_q.src_on), .inv_i(pc_q.inv),
        .from_i(s_idx_q), .limit_i(vl_q), .found_o(s_found), .idx_o(s_pick)
    );

    ves_next_pick #(.MAXVL(MAXVL), .IDX_W(IDX_W)) i_pick_dst (
        .mask_i(dmask_q), .on_i(pc_q.dst_on), .inv_i(pc_q.inv),
        .from_i(d_idx_q), .limit_i(vl_q), .found_o(d_found), .idx_o(d_pick)
    );

    ves_reg_map #(.IDX_W(IDX_W), .REG_W(REG_W)) i_map_src (
        .base_i(sbase_q), .is_vec_i(svec_q), .grp_i(s_pick),
        .glen_i(glen_q), .elem_i(elem_q), .reg_o(s_reg_nx)
    );

    ves_reg_map #(.IDX_W(IDX_W), .REG_W(REG_W)) i_map_dst (
        .base_i(dbase_q), .is_vec_i(dvec_q), .grp_i(d_pick),
        .glen_i(glen_q), .elem_i(elem_q), .reg_o(d_reg_nx)
    );

    always_comb begin
        pair_ok   = s_found && d_found;
        last_elem = ({1'b0, elem_q} + 3'd1) == glen_q;
        cut_short = (pc_q.src_on && !svec_q) || (pc_q.dst_on && !dvec_q);
    end

    assign busy = (state_q == SEQ_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= SEQ_IDLE;
            vl_q       <= '0;
            s_idx_q    <= '0;
            d_idx_q    <= '0;
            glen_q     <= 3'd1;
            elem_q     <= '0;
            svec_q     <= 1'b0;
            dvec_q     <= 1'b0;
            sbase_q    <= '0;
            dbase_q    <= '0;
            pc_q       <= '0;
            smask_q    <= '0;
            dmask_q    <= '0;
            issue      <= 1'b0;
            done       <= 1'b0;
            src_reg    <= '0;
            dst_reg    <= '0;
            resume_idx <= '0;
        end else begin
            issue <= 1'b0;
            done  <= 1'b0;
            if (state_q == SEQ_IDLE) begin
                if (start) begin
                    state_q <= SEQ_RUN;
                    vl_q    <= vl;
                    glen_q  <= group_len(svlen_code);
                    s_idx_q <= start_idx;
                    d_idx_q <= start_idx;
                    elem_q  <= '0;
                    svec_q  <= src_vec;
                    dvec_q  <= dst_vec;
                    sbase_q <= src_base;
                    dbase_q <= dst_base;
                    pc_q    <= decode_pred(pred_sel);
                    smask_q <= src_mask;
                    dmask_q <= dst_mask;
                end
            end else if (trap) begin
                state_q    <= SEQ_IDLE;
                resume_idx <= d_idx_q;
            end else if (pair_ok) begin
                issue   <= 1'b1;
                src_reg <= s_reg_nx;
                dst_reg <= d_reg_nx;
                if (last_elem) begin
                    elem_q  <= '0;
                    s_idx_q <= s_pick + IDX_W'(1);
                    // A predicated scalar ends the loop: park the destination
                    // index at VL so the next search comes up empty.
                    d_idx_q <= cut_short ? vl_q : d_pick + IDX_W'(1);
                end else begin
                    elem_q  <= elem_q + 2'd1;
                    s_idx_q <= s_pick;
                    d_idx_q <= d_pick;
                end
            end else begin
                state_q    <= SEQ_IDLE;
                done       <= 1'b1;
                resume_idx <= '0;
            end
        end
    end
endmodule

// File: rtl/vec_elem_seq_chk.sv
module vec_elem_seq_chk #(
    parameter int IDX_W = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             issue,
    input logic             done,
    input logic             trap,
    input logic [IDX_W-1:0] resume_idx
);
    assert_issue_done_excl_R9: assert property (@(posedge clk) disable iff (rst)
        !(issue && done));

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_done_clears_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> (resume_idx == '0));

    assert_issue_from_busy_R5: assert property (@(posedge clk) disable iff (rst)
        issue |-> $past(busy));

    assert_trap_freeze_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && trap) |=> (!busy && !issue && !done));

    assert_idle_trap_R8: assert property (@(posedge clk) disable iff (rst)
        (!busy && trap) |=> $stable(resume_idx));
endmodule

bind vec_elem_seq vec_elem_seq_chk #(.IDX_W(IDX_W)) i_chk (
    .clk(clk), .rst(rst), .busy(busy), .issue(issue),
    .done(done), .trap(trap), .resume_idx(resume_idx)
);

// File: tb/test_vec_elem_seq.sv
module test_vec_elem_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [6:0]  vl = '0;
    logic [1:0]  svlen_code = '0;
    logic [6:0]  start_idx = '0;
    logic        src_vec = 1'b0, dst_vec = 1'b0;
    logic [6:0]  src_base = '0, dst_base = '0;
    logic [2:0]  pred_sel = '0;
    logic [63:0] src_mask = '0, dst_mask = '0;
    logic        trap = 1'b0;
    logic        busy, issue, done;
    logic [6:0]  src_reg, dst_reg, resume_idx;

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;

    // Case setup held by the bench and fed to the model.
    int b_vl, b_sv, b_start, b_sel;
    bit b_svec, b_dvec;
    int b_sbase, b_dbase;
    logic [63:0] b_smask, b_dmask;
    int qs[$];
    int qd[$];

    vec_elem_seq i_vec_elem_seq (
        .clk(clk), .rst(rst), .start(start), .vl(vl), .svlen_code(svlen_code),
        .start_idx(start_idx), .src_vec(src_vec), .dst_vec(dst_vec),
        .src_base(src_base), .dst_base(dst_base), .pred_sel(pred_sel),
        .src_mask(src_mask), .dst_mask(dst_mask), .trap(trap),
        .busy(busy), .issue(issue), .src_reg(src_reg), .dst_reg(dst_reg),
        .done(done), .resume_idx(resume_idx)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            nerr = nerr + 1;
            $display("FAIL watchdog: got %0d cycles expected below 100000", cyc);
            $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic bit grp_en(input logic [63:0] m, input bit on, input bit inv, input int g);
        if (!on) return 1'b1;
        return m[g] ^ inv;
    endfunction

    // Behavioural model: list of register pairs, one per issue cycle.
    task automatic build_model();
        int len, s, d, sp, dp;
        bit son, don, inv, stop;
        len = b_sv + 1;
        son = b_sel[0];
        don = b_sel[1];
        inv = b_sel[2];
        stop = (son && !b_svec) || (don && !b_dvec);
        qs.delete();
        qd.delete();
        s = b_start;
        d = b_start;
        forever begin
            sp = -1;
            dp = -1;
            for (int g = s; g < b_vl; g++)
                if (sp < 0 && grp_en(b_smask, son, inv, g)) sp = g;
            for (int g = d; g < b_vl; g++)
                if (dp < 0 && grp_en(b_dmask, don, inv, g)) dp = g;
            if (sp < 0 || dp < 0) break;
            for (int e = 0; e < len; e++) begin
                qs.push_back((b_sbase + (b_svec ? sp * len : 0) + e) % 128);
                qd.push_back((b_dbase + (b_dvec ? dp * len : 0) + e) % 128);
            end
            if (stop) break;
            s = sp + 1;
            d = dp + 1;
        end
    endtask

    task automatic run(input string tag, input bit hold, input int trap_at);
        int n;
        build_model();
        n = qs.size();
        @(negedge clk);
        vl = 7'(b_vl);
        svlen_code = 2'(b_sv);
        start_idx = 7'(b_start);
        src_vec = b_svec;
        dst_vec = b_dvec;
        src_base = 7'(b_sbase);
        dst_base = 7'(b_dbase);
        pred_sel = 3'(b_sel);
        src_mask = b_smask;
        dst_mask = b_dmask;
        start = 1'b1;
        @(negedge clk);
        if (hold) begin
            // R1: new setup while busy must be ignored
            vl = 7'd1;
            src_base = 7'd99;
            pred_sel = 3'b011;
        end else begin
            start = 1'b0;
        end
        chk({tag, " R1 busy after start"}, busy, 1);
        chk({tag, " R1 no issue yet"}, issue, 0);
        for (int c = 1; c <= n + 1; c++) begin
            @(negedge clk);
            if (c <= n) begin
                chk({tag, " R5 issue"}, issue, 1);
                chk({tag, " R2 src_reg"}, src_reg, qs[c-1]);
                chk({tag, " R2 dst_reg"}, dst_reg, qd[c-1]);
                if (trap_at == c) begin
                    trap = 1'b1;
                    @(negedge clk);
                    trap = 1'b0;
                    start = 1'b0;
                    chk({tag, " R8 busy dropped"}, busy, 0);
                    chk({tag, " R8 no issue"}, issue, 0);
                    chk({tag, " R8 no done"}, done, 0);
                    // unpredicated, single-element groups: next group = start + issued
                    chk({tag, " R8 resume_idx"}, resume_idx, b_start + trap_at);
                    return;
                end
            end else begin
                chk({tag, " R7 done"}, done, 1);
                chk({tag, " R9 no issue with done"}, issue, 0);
                chk({tag, " R9 busy low at done"}, busy, 0);
                chk({tag, " R7 resume cleared"}, resume_idx, 0);
                start = 1'b0;
            end
        end
        @(negedge clk);
        chk({tag, " R7 done is one cycle"}, done, 0);
    endtask

    task automatic setup(input int v, input int sv, input int st, input int sel,
                         input bit svec, input bit dvec, input int sb, input int db,
                         input logic [63:0] sm, input logic [63:0] dm);
        b_vl = v; b_sv = sv; b_start = st; b_sel = sel;
        b_svec = svec; b_dvec = dvec; b_sbase = sb; b_dbase = db;
        b_smask = sm; b_dmask = dm;
    endtask

    initial begin
        int saved;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("reset busy", busy, 0);
        chk("reset issue", issue, 0);
        chk("reset done", done, 0);
        chk("reset resume_idx", resume_idx, 0);

        // R2 R5 plain vector/vector loop
        setup(5, 0, 0, 0, 1, 1, 8, 40, '0, '0);
        run("C1_r2_plain", 0, -1);
        // R3 three-element groups, scalar destination repeats base+e
        setup(3, 2, 0, 0, 1, 0, 0, 20, '0, '0);
        run("C2_r3_groups", 0, -1);
        // R4 source predicated only (selector 001)
        setup(8, 0, 0, 1, 1, 1, 0, 64, 64'hB2, '0);
        run("C3_r4_srcpred", 0, -1);
        // R5 twin predicate, different masks (selector 011)
        setup(7, 0, 0, 3, 1, 1, 10, 50, 64'h4D, 64'h62);
        run("C4_r5_twin", 0, -1);
        // R4 inverted twin predicate (selector 111) with two-element groups
        setup(6, 1, 0, 7, 1, 1, 2, 30, 64'h4D, 64'h62);
        run("C5_r4_inverted", 0, -1);
        // R4 reserved selector 100 with zero masks acts unpredicated
        setup(4, 0, 0, 4, 1, 1, 5, 70, '0, '0);
        run("C6_r4_reserved", 0, -1);
        // R6 predicated scalar destination (selector 010) ends after first group
        setup(8, 1, 0, 2, 1, 0, 12, 33, '0, 64'h28);
        run("C7_r6_dst_scalar", 0, -1);
        // R6 inverted predicated scalar source (selector 101)
        setup(8, 0, 0, 5, 0, 1, 7, 90, 64'hFFFF_FFFF_FFFF_FFF3, '0);
        run("C8_r6_src_scalar", 0, -1);
        // R7 VL of zero and start index at VL
        setup(0, 0, 0, 0, 1, 1, 0, 0, '0, '0);
        run("C9_r7_vl_zero", 0, -1);
        setup(5, 0, 5, 0, 1, 1, 0, 0, '0, '0);
        run("C10_r7_start_at_vl", 0, -1);
        // R7 nonzero start index
        setup(8, 0, 3, 0, 1, 1, 16, 48, '0, '0);
        run("C11_r7_start3", 0, -1);
        // R2 full length with register number wrap modulo 128
        setup(64, 0, 0, 0, 1, 1, 100, 127, '0, '0);
        run("C12_r2_wrap", 0, -1);
        // R1 start held and setup changed while busy
        setup(4, 1, 0, 0, 1, 1, 3, 60, '0, '0);
        run("C13_r1_hold", 1, -1);
        // R8 trap after three issues, then idle trap, then resume
        setup(10, 0, 2, 0, 1, 1, 0, 20, '0, '0);
        run("C14_r8_trap", 0, 3);
        saved = resume_idx;
        @(negedge clk);
        trap = 1'b1;
        @(negedge clk);
        trap = 1'b0;
        chk("R8 idle trap keeps busy low", busy, 0);
        chk("R8 idle trap keeps resume_idx", resume_idx, saved);
        setup(10, 0, saved, 0, 1, 1, 0, 20, '0, '0);
        run("C15_r8_resume", 0, -1);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule